// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Comparator with Lock Indication

This block compares a signal input with a comparison input, normally the divided feedback of an oscillator, and sends out a correction for a charge pump or loop filter outside the block. Only the rising edges of the two inputs count. Their high and low times do not matter, so pulse trains of any duty cycle are valid. Both inputs are asynchronous to the sampling clock. Each one passes through a synchronizer chain and then an edge detector before it reaches the comparison logic.

Two flags hold the result of the comparison. A signal edge sets the "raise" flag and a comparison edge sets the "lower" flag. Whenever both flags would be set at once, both clear on that same clock, so the detector has no dead zone. A three-state correction pin is modelled as a drive enable plus a driven value. The pin is driven high while only "raise" is set, driven low while only "lower" is set, and released at all other times.

A lock monitor measures how long each correction pulse lasts. The lock output goes high once a run of consecutive comparison periods has held every pulse to a short width. It drops as soon as one pulse grows past that width.

Top module: `pfd_lock_top`

## Requirements
- R1: Each input goes through SYNC_STAGES (default 2) flip-flops before edge detection, and only 0-to-1 transitions act. Changing the high time of either input without moving its rising edges leaves every output unchanged.
- R2: A synchronized signal edge sets the raise flag (`up_o`) and a synchronized comparison edge sets the lower flag (`dn_o`). When both flags would be set on the same clock, both are 0 after that clock. The two flags are never 1 together.
- R3: `pin_en_o` is 1 exactly when one flag is set. `pin_val_o` is 1 when the raise flag is the one set and 0 when the lower flag is the one set.
- R4: When the rising edges of the two inputs arrive on the same sampling clock every period, `pin_en_o` stays 0.
- R5: When the signal input has the higher frequency, the pin is never driven to 0 (no cycle with `pin_en_o`=1 and `pin_val_o`=0), and it is driven to 1 for part of the time.
- R6: When the signal input has the lower frequency, the pin is never driven to 1, and it is driven to 0 for part of the time.
- R7: At equal frequency, with each signal edge arriving D sampling clocks before the matching comparison edge, every correction pulse is driven 1 and lasts exactly D clocks.
- R8: At equal frequency, with each comparison edge arriving D clocks before the matching signal edge, every correction pulse is driven 0 and lasts exactly D clocks.
- R9: `lock_o` rises on the clock that registers the LOCK_CYCLES-th consecutive comparison edge (default 16) during which no pulse has exceeded PULSE_LIMIT clocks (default 2). It appears three clocks after that comparison rising edge is applied. Pulses of exactly PULSE_LIMIT clocks still allow lock.
- R10: `lock_o` falls one clock after the first cycle in which a pulse reaches PULSE_LIMIT+1 clocks. Lock is never reached while every period holds a wider pulse.
- R11: During and right after reset, `up_o`, `dn_o`, `pin_en_o`, `pin_val_o` and `lock_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Signal input (asynchronous) |
| cmp_in | input | 1 | Comparison input, e.g. divided feedback (asynchronous) |
| up_o | output | 1 | Raise flag |
| dn_o | output | 1 | Lower flag |
| pin_en_o | output | 1 | Drive enable of the modelled three-state pin |
| pin_val_o | output | 1 | Value on the modelled pin while it is driven |
| lock_o | output | 1 | Lock indication |

## Verification
Two pairs of unequal periods are used, one with the signal input faster and one with it slower. Each pair shows that the pin holds a single polarity, and that a frequency error is not mistaken for a phase error. Equal periods with fixed offsets in both directions measure the exact width and polarity of each pulse. The same offsets are repeated with very narrow and very wide high times to show that only edges matter. Coincident edges must leave the pin released, and they set lock on exactly the required comparison edge. Offsets of two and three clocks fall on either side of the pulse-width limit. A locked loop that is moved to a three-clock offset checks the exact clock on which lock falls.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;

  // Next state of the raise/lower pair: edges set, coincidence clears both.
  function automatic pfd_flags_t pfd_flags_next(pfd_flags_t cur, logic sig_rise, logic cmp_rise);
    pfd_flags_t nxt;
    nxt.up = cur.up | sig_rise;
    nxt.dn = cur.dn | cmp_rise;
    if (nxt.up && nxt.dn) begin
      nxt = '0;
    end
    return nxt;
  endfunction

  // A pulse is too wide once it is active after already lasting `limit` cycles.
  function automatic logic pfd_too_wide(logic active, int unsigned run, int unsigned limit);
    return active && (run >= limit);
  endfunction

  // Saturating increment used by the run and period counters.
  function automatic int unsigned pfd_sat_inc(int unsigned val, int unsigned lim);
    return (val >= lim) ? lim : val + 1;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
`timescale 1ns/1ps
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] stage_q;
  logic              hist_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~hist_q;

  // R1: a detected edge lasts a single sampling clock
  a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_flag_core.sv
`timescale 1ns/1ps
module pfd_flag_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sig_rise,
  input  logic cmp_rise,
  output logic up_o,
  output logic dn_o,
  output logic pin_en_o,
  output logic pin_val_o
);

  pfd_flags_t flags_q;
  pfd_flags_t flags_d;

  always_comb flags_d = pfd_flags_next(flags_q, sig_rise, cmp_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign up_o      = flags_q.up;
  assign dn_o      = flags_q.dn;
  assign pin_en_o  = flags_q.up ^ flags_q.dn;
  assign pin_val_o = flags_q.up;

  // R2: the two flags never coexist
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  // R2: raise flag only appears after a signal edge
  a_r2_up_from_sig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_o) |-> $past(sig_rise));

  // R4: coincident edges leave the pin released
  a_r4_coincide_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_rise && cmp_rise) |=> !pin_en_o);

endmodule

// File: rtl/pfd_lock_mon.sv
`timescale 1ns/1ps
module pfd_lock_mon
  import pfd_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int PULSE_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_active,
  input  logic cmp_rise,
  output logic too_wide_o,
  output logic lock_o
);

  localparam int RUN_W  = $clog2(PULSE_LIMIT + 2);
  localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);

  logic [RUN_W-1:0]  run_q;
  logic [GOOD_W-1:0] good_q;

  assign too_wide_o = pfd_too_wide(pulse_active, 32'(run_q), PULSE_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!pulse_active) begin
      run_q <= '0;
    end else begin
      run_q <= RUN_W'(pfd_sat_inc(32'(run_q), PULSE_LIMIT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (too_wide_o) begin
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (cmp_rise) begin
      good_q <= GOOD_W'(pfd_sat_inc(32'(good_q), LOCK_CYCLES));
      if (32'(good_q) == LOCK_CYCLES - 1) lock_o <= 1'b1;
    end
  end

  // R10: an over-wide pulse removes lock on the next clock
  a_r10_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    too_wide_o |=> !lock_o);

  // R9: lock is only gained on a comparison edge
  a_r9_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(cmp_rise));

  // R9: lock is never gained in a cycle holding a wide pulse
  a_r9_lock_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> !$past(too_wide_o));

endmodule

// File: rtl/pfd_lock_top.sv
`timescale 1ns/1ps
module pfd_lock_top #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 16,
  parameter int PULSE_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic cmp_in,
  output logic up_o,
  output logic dn_o,
  output logic pin_en_o,
  output logic pin_val_o,
  output logic lock_o
);

  logic sig_rise;
  logic cmp_rise;
  logic too_wide;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_sig (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise_o(sig_rise)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_cmp (
    .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise_o(cmp_rise)
  );

  pfd_flag_core u_core (
    .clk(clk), .rst_n(rst_n),
    .sig_rise(sig_rise), .cmp_rise(cmp_rise),
    .up_o(up_o), .dn_o(dn_o),
    .pin_en_o(pin_en_o), .pin_val_o(pin_val_o)
  );

  pfd_lock_mon #(.LOCK_CYCLES(LOCK_CYCLES), .PULSE_LIMIT(PULSE_LIMIT)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .pulse_active(pin_en_o), .cmp_rise(cmp_rise),
    .too_wide_o(too_wide), .lock_o(lock_o)
  );

  // R3: a driven pin carries the polarity of the set flag
  a_r3_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en_o && dn_o) |-> !pin_val_o);

  // R2: lower flag only appears after a comparison edge
  a_r2_dn_from_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_o) |-> $past(cmp_rise));

endmodule

// File: tb/pfd_lock_top_tb.sv
`timescale 1ns/1ps
module pfd_lock_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic cmp_in = 1'b0;
  logic up_o, dn_o, pin_en_o, pin_val_o, lock_o;

  int n_checks = 0;
  int n_fail   = 0;

  // statistics filled by run_waves
  int drv1, drv0, runs, wmin, wmax, mixed, lock_hi;

  always #2 clk = ~clk;

  pfd_lock_top u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cmp_in(cmp_in),
    .up_o(up_o), .dn_o(dn_o), .pin_en_o(pin_en_o),
    .pin_val_o(pin_val_o), .lock_o(lock_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    sig_in = 1'b0;
    cmp_in = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic wave(int i, int per, int hi, int ofs);
    return (i >= ofs) && (((i - ofs) % per) < hi);
  endfunction

  // Drives both inputs for ncyc clocks, collecting pin statistics after skip.
  task automatic run_waves(input int sp, input int sh, input int so,
                           input int cp, input int ch, input int co,
                           input int ncyc, input int skip);
    int run = 0;
    int rval = 0;
    drv1 = 0; drv0 = 0; runs = 0; wmin = 1000000; wmax = 0; mixed = 0; lock_hi = 0;
    for (int i = 0; i < ncyc + 4; i++) begin
      @(negedge clk);
      if (i >= skip) begin
        if (pin_en_o && pin_val_o)  drv1++;
        if (pin_en_o && !pin_val_o) drv0++;
        if (lock_o) lock_hi++;
      end
      if (pin_en_o) begin
        if (run == 0) rval = int'(pin_val_o);
        else if (rval != int'(pin_val_o)) mixed++;
        run++;
      end else if (run > 0) begin
        if (i - run >= skip) begin
          runs++;
          if (run < wmin) wmin = run;
          if (run > wmax) wmax = run;
        end
        run = 0;
      end
      sig_in = (i < ncyc) ? wave(i, sp, sh, so) : 1'b0;
      cmp_in = (i < ncyc) ? wave(i, cp, ch, co) : 1'b0;
    end
  endtask

  task automatic t_reset_state();
    sig_in = 1'b0; cmp_in = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!up_o && !dn_o, "R11", "flags in reset", int'({up_o, dn_o}), 0);
    check(!pin_en_o && !pin_val_o, "R11", "pin in reset", int'({pin_en_o, pin_val_o}), 0);
    check(!lock_o, "R11", "lock in reset", int'(lock_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pin_en_o && !lock_o, "R11", "outputs after release", int'({pin_en_o, lock_o}), 0);
  endtask

  task automatic t_faster();
    do_reset();
    run_waves(8, 4, 0, 13, 2, 0, 600, 10);
    check(drv0 == 0, "R5", "cycles driven 0 with faster signal", drv0, 0);
    check(drv1 > 0, "R5", "cycles driven 1 with faster signal", drv1, 1);
    check(lock_hi == 0, "R10", "lock samples with frequency error", lock_hi, 0);
  endtask

  task automatic t_slower();
    do_reset();
    run_waves(13, 9, 0, 8, 1, 0, 600, 10);
    check(drv1 == 0, "R6", "cycles driven 1 with slower signal", drv1, 0);
    check(drv0 > 0, "R6", "cycles driven 0 with slower signal", drv0, 1);
  endtask

  task automatic t_phase(input int d, input bit sig_first, input int sh, input int ch);
    string rq;
    rq = sig_first ? "R7" : "R8";
    do_reset();
    if (sig_first) run_waves(20, sh, 0, 20, ch, d, 400, 0);
    else           run_waves(20, sh, d, 20, ch, 0, 400, 0);
    check(runs >= 15, rq, "number of pulses", runs, 19);
    check(wmin == d && wmax == d, rq, "pulse width min/max", wmin * 100 + wmax, d * 101);
    if (sig_first) check(drv0 == 0, rq, "cycles driven 0", drv0, 0);
    else           check(drv1 == 0, rq, "cycles driven 1", drv1, 0);
    check(mixed == 0, "R3", "polarity change inside a pulse", mixed, 0);
  endtask

  // Coincident edges with unequal duty: pin released, lock on 16th edge.
  task automatic t_coincide_lock();
    int lock_pre = 0;
    int lock_post = 0;
    int pin_any = 0;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pin_en_o) pin_any++;
      if (i == 152) lock_pre = int'(lock_o);
      if (i == 153) lock_post = int'(lock_o);
      sig_in = wave(i, 10, 1, 0);
      cmp_in = wave(i, 10, 8, 0);
    end
    check(pin_any == 0, "R4", "driven cycles with coincident edges", pin_any, 0);
    check(pin_any == 0, "R1", "duty difference ignored", pin_any, 0);
    check(lock_pre == 0, "R9", "lock two clocks after 16th edge", lock_pre, 0);
    check(lock_post == 1, "R9", "lock three clocks after 16th edge", lock_post, 1);
  endtask

  task automatic t_lock_limit();
    do_reset();
    run_waves(20, 10, 0, 20, 10, 2, 400, 0);
    check(lock_o == 1'b1, "R9", "lock with 2-clock pulses", int'(lock_o), 1);
    do_reset();
    run_waves(20, 10, 0, 20, 10, 3, 400, 0);
    check(lock_hi == 0, "R10", "lock samples with 3-clock pulses", lock_hi, 0);
  endtask

  task automatic t_lock_drop();
    int run = 0;
    int seen = 0;
    int at_edge = 0;
    int after = 1;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      sig_in = wave(i, 10, 5, 0);
      cmp_in = wave(i, 10, 5, 0);
    end
    check(lock_o == 1'b1, "R9", "locked before offset step", int'(lock_o), 1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (seen == 1) begin
        after = int'(lock_o);
        seen = 2;
      end
      if (pin_en_o) run++;
      else run = 0;
      if (run == 3 && seen == 0) begin
        at_edge = int'(lock_o);
        seen = 1;
      end
      sig_in = wave(i, 10, 5, 0);
      cmp_in = wave(i, 10, 5, 3);
    end
    check(at_edge == 1, "R10", "lock during first over-wide cycle", at_edge, 1);
    check(after == 0, "R10", "lock one clock later", after, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_faster();
    t_slower();
    t_phase(4, 1'b1, 10, 10);
    t_phase(5, 1'b0, 10, 10);
    t_phase(4, 1'b1, 1, 15);
    t_phase(3, 1'b0, 17, 2);
    t_coincide_lock();
    t_lock_limit();
    t_lock_drop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule